// File: doc/BRIEF.md
# I2C Controller FIFO and Interrupt Register Bank

This block is the software-visible register bank of an I2C master controller. A CPU reaches it through a simple 32-bit register read/write port. The bank holds a transmit word queue that the CPU fills and the transfer engine drains, and a receive word queue that the engine fills and the CPU drains. It also holds a queue control register with self-clearing flush bits and trigger levels, and an occupancy register. Beside these sit an interrupt mask and a sticky interrupt status register that the CPU clears by writing ones.

The transfer engine uses dedicated pop and push ports and reports bus events on single-cycle pulse inputs. The bank merges the masked status into one interrupt line. The packet-complete event always drives that line, whatever the mask says. A parameter selects a second address layout, used when the bank sits inside a wrapper block. In that layout every offset moves up, and the amount depends on which region the offset falls in.

Top module: `i2c_fifo_regbank`

## Requirements
- R1: After reset both queues are empty, the sticky interrupt bits (7:2) are clear, and the mask, control and configuration registers read zero. The occupancy register therefore reads 0x80, and the interrupt line is low.
- R2: Words written to the transmit data offset (0x050) leave through the engine pop port in the order they were written. `eng_tx_valid` is high exactly while the transmit queue holds a word.
- R3: A write to the transmit data offset while the queue holds DEPTH (8) words is dropped, and it sets interrupt status bit 5 (transmit overflow).
- R4: A read of the receive data offset (0x054) returns the oldest engine-pushed word and removes it. A read while the queue is empty returns zero and sets interrupt status bit 4 (receive underflow).
- R5: The occupancy register (0x060) reports free transmit slots in bits 7:4 and filled receive words in bits 3:0.
- R6: In the control register (0x05C), writing bit 1 empties the transmit queue and writing bit 0 empties the receive queue. Each bit reads 1 for the two cycles after the write and then reads 0. Bits 7:5 hold the transmit trigger level and bits 4:2 hold the receive trigger level, and both read back as written.
- R7: Interrupt status bit 1 is high while the free transmit slots exceed the transmit trigger level. Bit 0 is high while the filled receive words exceed the receive trigger level.
- R8: The event inputs set sticky status bits: packet complete sets bit 7, all packets complete sets bit 6, no acknowledge sets bit 3 and arbitration lost sets bit 2. Writing a 1 to a sticky bit of the status register (0x068) clears it, writing a 0 leaves it unchanged, and an event in the same cycle wins over the clear.
- R9: `irq` is high when any status bit is set together with its bit in the mask register (0x064), or when bit 7 is set whatever the mask.
- R10: With `ALT_MAP` set, offsets at or above 0x050 move up by 0x10 and offsets below 0x050 move up by 0x40. A read of an offset that maps to no register returns zero.
- R11: The configuration register (0x000) and the clock divisor register (0x06C) store all 32 written bits. In the divisor, the high-speed value sits in bits 15:0 and the standard/fast value sits in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at its offset) |
| reg_addr | input | AW | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| eng_tx_pop | input | 1 | Engine takes the head transmit word |
| eng_tx_data | output | 32 | Head of the transmit queue |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_rx_push | input | 1 | Engine writes a received word |
| eng_rx_data | input | 32 | Received word |
| eng_rx_ready | output | 1 | Receive queue has space |
| ev_pkt_done | input | 1 | Packet-complete pulse |
| ev_all_done | input | 1 | All-packets-complete pulse |
| ev_nack | input | 1 | No-acknowledge pulse |
| ev_arb_lost | input | 1 | Arbitration-lost pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take two things for granted about the transfer engine. It never pops an empty transmit queue, and it never pushes into a full receive queue. Each side must therefore heed `eng_tx_valid` and `eng_rx_ready`. The bench keeps a queue model of both queues and only issues an engine pop or push when that model shows a word or a free slot. Its random CPU traffic, by contrast, deliberately writes to a full queue and reads from an empty one, because the register port is allowed to do both.

// File: rtl/i2c_fifo_regbank.sv
module i2c_fifo_regbank #(
  parameter bit ALT_MAP   = 1'b0,
  parameter int DEPTH     = 8,
  parameter int AW        = 12,
  parameter int FLUSH_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          eng_tx_pop,
  output logic [31:0]   eng_tx_data,
  output logic          eng_tx_valid,
  input  logic          eng_rx_push,
  input  logic [31:0]   eng_rx_data,
  output logic          eng_rx_ready,
  input  logic          ev_pkt_done,
  input  logic          ev_all_done,
  input  logic          ev_nack,
  input  logic          ev_arb_lost,
  output logic          irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int FW = $clog2(FLUSH_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  function automatic logic [AW-1:0] place(input logic [AW-1:0] off);
    if (!ALT_MAP) return off;
    return (off >= AW'(12'h050)) ? off + AW'(12'h010) : off + AW'(12'h040);
  endfunction

  localparam logic [AW-1:0] A_CFG  = place(AW'(12'h000));
  localparam logic [AW-1:0] A_TXD  = place(AW'(12'h050));
  localparam logic [AW-1:0] A_RXD  = place(AW'(12'h054));
  localparam logic [AW-1:0] A_CTL  = place(AW'(12'h05C));
  localparam logic [AW-1:0] A_OCC  = place(AW'(12'h060));
  localparam logic [AW-1:0] A_MSK  = place(AW'(12'h064));
  localparam logic [AW-1:0] A_IST  = place(AW'(12'h068));
  localparam logic [AW-1:0] A_DIV  = place(AW'(12'h06C));

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  logic wr_cfg, wr_txd, rd_rxd, wr_ctl, wr_msk, wr_ist, wr_div;
  assign wr_cfg = reg_wr && reg_addr == A_CFG;
  assign wr_txd = reg_wr && reg_addr == A_TXD;
  assign rd_rxd = reg_rd && reg_addr == A_RXD;
  assign wr_ctl = reg_wr && reg_addr == A_CTL;
  assign wr_msk = reg_wr && reg_addr == A_MSK;
  assign wr_ist = reg_wr && reg_addr == A_IST;
  assign wr_div = reg_wr && reg_addr == A_DIV;

  logic tx_flush_go, rx_flush_go;
  assign tx_flush_go = wr_ctl && reg_wdata[1];
  assign rx_flush_go = wr_ctl && reg_wdata[0];

  // transmit queue
  logic [31:0]   tx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic          tx_full, tx_push, tx_take;
  assign tx_full = tx_cnt == FULL;
  assign tx_push = wr_txd && !tx_full;
  assign tx_take = eng_tx_pop && tx_cnt != '0 && !tx_flush_go;

  always_ff @(posedge clk) begin
    if (!rst_n || tx_flush_go) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= bump(tx_wp);
      if (tx_take) tx_rp <= bump(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_take);
    end
  end

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= reg_wdata;

  assign eng_tx_data  = tx_mem[tx_rp];
  assign eng_tx_valid = tx_cnt != '0;

  // receive queue
  logic [31:0]   rx_mem [DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic          rx_put, rx_take;
  assign rx_put  = eng_rx_push && rx_cnt != FULL && !rx_flush_go;
  assign rx_take = rd_rxd && rx_cnt != '0 && !rx_flush_go;

  always_ff @(posedge clk) begin
    if (!rst_n || rx_flush_go) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_put)  rx_wp <= bump(rx_wp);
      if (rx_take) rx_rp <= bump(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_put) - CW'(rx_take);
    end
  end

  always_ff @(posedge clk)
    if (rx_put) rx_mem[rx_wp] <= eng_rx_data;

  assign eng_rx_ready = rx_cnt != FULL;

  // control: trigger levels and flush timers
  logic [2:0]    tx_trig, rx_trig;
  logic [FW-1:0] tx_fl, rx_fl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_trig <= '0;
      rx_trig <= '0;
      tx_fl   <= '0;
      rx_fl   <= '0;
    end else begin
      if (wr_ctl) begin
        tx_trig <= reg_wdata[7:5];
        rx_trig <= reg_wdata[4:2];
      end
      if (tx_flush_go)       tx_fl <= FW'(FLUSH_CYC);
      else if (tx_fl != '0)  tx_fl <= tx_fl - FW'(1);
      if (rx_flush_go)       rx_fl <= FW'(FLUSH_CYC);
      else if (rx_fl != '0)  rx_fl <= rx_fl - FW'(1);
    end
  end

  logic [CW-1:0] tx_free;
  logic          tx_req, rx_req;
  assign tx_free = FULL - tx_cnt;
  assign tx_req  = tx_free > CW'(tx_trig);
  assign rx_req  = rx_cnt  > CW'(rx_trig);

  // interrupts: bits 7:2 sticky, 1:0 live
  logic [5:0] sticky, sets, clrs;
  logic [7:0] mask;
  logic [7:0] ist;
  assign sets = {ev_pkt_done, ev_all_done, wr_txd && tx_full,
                 rd_rxd && rx_cnt == '0, ev_nack, ev_arb_lost};
  assign clrs = wr_ist ? reg_wdata[7:2] : 6'b0;
  assign ist  = {sticky, tx_req, rx_req};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky <= '0;
      mask   <= '0;
    end else begin
      sticky <= (sticky & ~clrs) | sets;
      if (wr_msk) mask <= reg_wdata[7:0];
    end
  end

  assign irq = |(ist & mask) || sticky[5];

  // plain storage
  logic [31:0] cfg_q, div_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      div_q <= '0;
    end else begin
      if (wr_cfg) cfg_q <= reg_wdata;
      if (wr_div) div_q <= reg_wdata;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CFG)      reg_rdata = cfg_q;
    else if (reg_addr == A_RXD) reg_rdata = (rx_cnt != '0) ? rx_mem[rx_rp] : '0;
    else if (reg_addr == A_CTL) reg_rdata = {24'b0, tx_trig, rx_trig, tx_fl != '0, rx_fl != '0};
    else if (reg_addr == A_OCC) reg_rdata = {24'b0, 4'(tx_free), 4'(rx_cnt)};
    else if (reg_addr == A_MSK) reg_rdata = {24'b0, mask};
    else if (reg_addr == A_IST) reg_rdata = {24'b0, ist};
    else if (reg_addr == A_DIV) reg_rdata = div_q;
  end

  // assertions
  assert_tx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL);
  assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd && tx_full) |=> (sticky[3] && tx_full));
  assert_eng_pop_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_tx_pop |-> eng_tx_valid);
  assert_eng_push_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rx_push |-> eng_rx_ready);
  assert_underflow_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && rx_cnt == '0) |=> sticky[2]);
  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush_go |=> (tx_cnt == '0 && tx_fl != '0));
  assert_w1c_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ist && reg_wdata[3] && !ev_nack) |=> !sticky[1]);
  assert_pkt_unmasked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sticky[5] |-> irq);
endmodule

// File: tb/i2c_fifo_regbank_tb_top.sv
`timescale 1ns/1ps
module i2c_fifo_regbank_tb_top;
  localparam int AW = 12;
  localparam real HALF = 2.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(HALF) clk = ~clk;

  logic          reg_wr = 0, reg_rd = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0, reg_rdata, alt_rdata;
  logic          eng_tx_pop = 0, eng_rx_push = 0;
  logic [31:0]   eng_rx_data = '0, eng_tx_data, alt_tx_data;
  logic          eng_tx_valid, eng_rx_ready, alt_tx_valid, alt_rx_ready;
  logic          ev_pkt = 0, ev_all = 0, ev_nack = 0, ev_arb = 0;
  logic          irq, alt_irq;

  i2c_fifo_regbank #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_tx_pop(eng_tx_pop),
    .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .eng_rx_ready(eng_rx_ready), .ev_pkt_done(ev_pkt),
    .ev_all_done(ev_all), .ev_nack(ev_nack), .ev_arb_lost(ev_arb), .irq(irq));

  i2c_fifo_regbank #(.ALT_MAP(1'b1), .AW(AW)) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(alt_rdata), .eng_tx_pop(1'b0),
    .eng_tx_data(alt_tx_data), .eng_tx_valid(alt_tx_valid), .eng_rx_push(1'b0),
    .eng_rx_data(32'h0), .eng_rx_ready(alt_rx_ready), .ev_pkt_done(1'b0),
    .ev_all_done(1'b0), .ev_nack(1'b0), .ev_arb_lost(1'b0), .irq(alt_irq));

  localparam logic [AW-1:0] O_CFG = 12'h000, O_TXD = 12'h050, O_RXD = 12'h054,
    O_CTL = 12'h05C, O_OCC = 12'h060, O_MSK = 12'h064, O_IST = 12'h068, O_DIV = 12'h06C;

  int checks = 0, errors = 0;
  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  logic [7:0]  m_sticky = '0;
  logic [7:0]  m_mask = '0;
  int          m_ttrig = 0, m_rtrig = 0;

  function automatic logic [31:0] exp_occ();
    return {24'b0, 4'(8 - txq.size()), 4'(rxq.size())};
  endfunction
  function automatic logic [31:0] exp_ist();
    return {24'b0, m_sticky[7:2], (8 - txq.size()) > m_ttrig, rxq.size() > m_rtrig};
  endfunction
  function automatic logic exp_irq();
    logic [7:0] s;
    s = exp_ist();
    return (|(s & m_mask)) || s[7];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks are entered at a falling edge and return at one
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask
  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    #0.5 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask
  task automatic rd_alt(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5 d = alt_rdata;
    @(negedge clk);
  endtask
  task automatic tx_write(input logic [31:0] d);
    if (txq.size() == 8) m_sticky[5] = 1'b1; else txq.push_back(d);
    wr(O_TXD, d);
  endtask
  task automatic eng_pop(input string req);
    eng_tx_pop = 1;
    #0.5 check(req, eng_tx_data, txq[0]);
    void'(txq.pop_front());
    @(negedge clk);
    eng_tx_pop = 0;
  endtask
  task automatic eng_push(input logic [31:0] d);
    eng_rx_push = 1; eng_rx_data = d;
    rxq.push_back(d);
    @(negedge clk);
    eng_rx_push = 0;
  endtask
  task automatic rx_read(input string req);
    logic [31:0] v, e;
    if (rxq.size() == 0) begin e = 0; m_sticky[4] = 1'b1; end
    else e = rxq.pop_front();
    rd(O_RXD, v);
    check(req, v, e);
  endtask
  task automatic pulse(input int which);
    case (which)
      0: begin ev_pkt = 1; m_sticky[7] = 1; end
      1: begin ev_all = 1; m_sticky[6] = 1; end
      2: begin ev_nack = 1; m_sticky[3] = 1; end
      default: begin ev_arb = 1; m_sticky[2] = 1; end
    endcase
    @(negedge clk);
    {ev_pkt, ev_all, ev_nack, ev_arb} = '0;
  endtask
  task automatic clear(input logic [7:0] w);
    m_sticky = m_sticky & ~{w[7:2], 2'b00};
    wr(O_IST, {24'b0, w});
  endtask
  task automatic status_check(input string req);
    logic [31:0] v;
    check({req, " irq"}, {31'b0, irq}, {31'b0, exp_irq()});
    rd(O_OCC, v); check({req, " occupancy"}, v, exp_occ());
    rd(O_IST, v); check({req, " int status"}, v, exp_ist());
  endtask

  initial begin
    #(HALF * 2 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(O_OCC, v); check("R1 occupancy", v, 32'h80);
    rd(O_IST, v); check("R1 int status", v, 32'h02);
    rd(O_CTL, v); check("R1 control", v, 32'h0);
    rd(O_MSK, v); check("R1 mask", v, 32'h0);
    check("R1 tx valid", {31'b0, eng_tx_valid}, 32'h0);

    // R11 storage registers
    wr(O_CFG, 32'hA5A5_0F0F); rd(O_CFG, v); check("R11 config", v, 32'hA5A5_0F0F);
    wr(O_DIV, 32'h0019_0001); rd(O_DIV, v); check("R11 divisor", v, 32'h0019_0001);
    check("R11 std/fast field", {16'b0, v[31:16]}, 32'h19);

    // R6 trigger fields
    wr(O_CTL, 32'hA8); m_ttrig = 5; m_rtrig = 2;
    rd(O_CTL, v); check("R6 trigger readback", v, 32'hA8);

    // R7 thresholds on transmit side, R5 layout
    tx_write(32'h1111_0001); tx_write(32'h1111_0002);
    rd(O_IST, v); check("R7 tx request free=6", {31'b0, v[1]}, 32'h1);
    tx_write(32'h1111_0003);
    rd(O_IST, v); check("R7 tx request free=5", {31'b0, v[1]}, 32'h0);
    for (int i = 4; i <= 8; i++) tx_write(32'h1111_0000 + i);
    rd(O_OCC, v); check("R5 full transmit", v, 32'h00);
    // R3 overflow
    tx_write(32'hDEAD_BEEF);
    rd(O_IST, v); check("R3 overflow flag", {31'b0, v[5]}, 32'h1);
    rd(O_OCC, v); check("R3 word dropped", v, 32'h00);
    // R2 ordering
    for (int i = 0; i < 8; i++) eng_pop("R2 pop order");
    check("R2 valid low when empty", {31'b0, eng_tx_valid}, 32'h0);

    // R4 receive path and R7 receive threshold
    eng_push(32'h2222_0001); eng_push(32'h2222_0002);
    rd(O_IST, v); check("R7 rx request 2 words", {31'b0, v[0]}, 32'h0);
    eng_push(32'h2222_0003);
    rd(O_IST, v); check("R7 rx request 3 words", {31'b0, v[0]}, 32'h1);
    rd(O_OCC, v); check("R5 rx count", v, 32'h83);
    for (int i = 0; i < 3; i++) rx_read("R4 read order");
    rx_read("R4 empty read zero");
    rd(O_IST, v); check("R4 underflow flag", {31'b0, v[4]}, 32'h1);

    // R8 clear semantics
    pulse(2);
    wr(O_IST, 32'h0);
    rd(O_IST, v); check("R8 zero write keeps", v, exp_ist());
    clear(8'h20);
    rd(O_IST, v); check("R8 clear bit5 only", v, exp_ist());
    check("R8 bit4 kept", {31'b0, v[4]}, 32'h1);
    // event wins over clear in the same cycle
    ev_nack = 1; wr(O_IST, 32'h08); ev_nack = 0;
    rd(O_IST, v); check("R8 event beats clear", {31'b0, v[3]}, 32'h1);
    clear(8'hFC);

    // R9 interrupt line
    pulse(2);
    check("R9 masked nack", {31'b0, irq}, 32'h0);
    pulse(0);
    check("R9 packet ignores mask", {31'b0, irq}, 32'h1);
    clear(8'h80);
    check("R9 packet cleared", {31'b0, irq}, 32'h0);
    wr(O_MSK, 32'h08); m_mask = 8'h08;
    check("R9 unmasked nack", {31'b0, irq}, 32'h1);
    clear(8'hFC); wr(O_MSK, 32'h0); m_mask = 0;

    // R6 flush behaviour
    tx_write(32'h3); tx_write(32'h4); tx_write(32'h5);
    eng_push(32'h6); eng_push(32'h7);
    wr(O_CTL, 32'hAA); txq.delete();
    rd(O_CTL, v); check("R6 tx flush busy 1", v, 32'hAA);
    rd(O_CTL, v); check("R6 tx flush busy 2", v, 32'hAA);
    rd(O_CTL, v); check("R6 tx flush done", v, 32'hA8);
    rd(O_OCC, v); check("R6 tx emptied rx kept", v, 32'h82);
    wr(O_CTL, 32'hA9); rxq.delete();
    rd(O_CTL, v); check("R6 rx flush busy", {31'b0, v[0]}, 32'h1);
    rd(O_CTL, v); rd(O_CTL, v); check("R6 rx flush done", v, 32'hA8);
    rd(O_OCC, v); check("R6 rx emptied", v, 32'h80);

    // R10 alternate layout
    wr(12'h040, 32'h1234_5678);
    rd_alt(12'h040, v); check("R10 alt config", v, 32'h1234_5678);
    wr(12'h07C, 32'h0019_0003);
    rd_alt(12'h07C, v); check("R10 alt divisor", v, 32'h0019_0003);
    rd_alt(12'h070, v); check("R10 alt occupancy", v, 32'h80);
    rd_alt(O_CFG, v); check("R10 alt old config offset", v, 32'h0);
    rd(O_CFG, v); check("R10 primary config untouched", v, 32'hA5A5_0F0F);
    rd(12'h070, v); check("R10 unmapped reads zero", v, 32'h0);

    // random phase
    m_mask = 8'($urandom); wr(O_MSK, {24'b0, m_mask});
    for (int n = 0; n < 600; n++) begin
      case ($urandom_range(0, 6))
        0: tx_write($urandom);
        1: if (txq.size() > 0) eng_pop("R2 random pop");
        2: if (rxq.size() < 8) eng_push($urandom);
        3: rx_read("R4 random read");
        4: pulse($urandom_range(0, 3));
        5: status_check("R7 R8 R9 random");
        default: clear(8'($urandom));
      endcase
    end
    status_check("R5 final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule